// File: doc/BRIEF.md
# Pin Interrupt Trigger Unit

This block watches a bank of input pins and turns chosen pin activity into a single interrupt request. Pin values arrive as a parallel vector together with a valid strobe; the vector and the strobe pass through a two-flop synchronizer, and only strobed samples are accepted. For each pin the block compares the accepted sample with the one before it, or looks at the accepted level itself. Three configuration bits per pin select one of five trigger modes.

When a pin's trigger fires, its status bit is set and stays set until software writes a one to that bit. A per-pin enable decides whether a set status bit contributes to the interrupt output. The interrupt output is a registered OR over all enabled status bits. Software reaches enables, trigger bits and status through a small word-addressed register bus. A read returns its data one clock after the read strobe.

Top module: `pin_irq_unit`

## Requirements
- R1: A pin whose enable bit is clear never drives `irq_out` high, but its status bit still records trigger events. The enable register is at word address 0, with bit n for pin n.
- R2: With the level bit (address 2) and the dual bit (address 3) clear, a clear polarity bit (address 1) makes the pin trigger on a falling edge. A set polarity bit makes it trigger on a rising edge.
- R3: With the dual bit set and the level bit clear, both rising and falling edges trigger, whatever the polarity bit holds.
- R4: With the level bit set, the pin triggers while its accepted sample is high (polarity 1) or low (polarity 0). Its status bit cannot be cleared while that level persists.
- R5: At word address 4, writing a one to a status bit clears it, and writing a zero leaves it unchanged.
- R6: When a pin's trigger fires in the same cycle as a write-one-to-clear of that pin, the status bit ends up set.
- R7: After reset, all enable, polarity, level and dual bits read zero, all status bits read zero, and `irq_out` is low.
- R8: A read of address 4 returns the status of every pin in one word, bit n for pin n. `reg_rdata` carries the value in the cycle after `reg_rd`.
- R9: `irq_out` is high one cycle after any pin has both its status bit and its enable bit set, and low one cycle after no pin does.
- R10: Pin changes are seen only through samples strobed by `pins_vld`. The first accepted sample after reset only primes the comparison and fires no trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | PINS | Parallel pin values |
| pins_vld | input | 1 | Strobe marking `pins_in` as a new sample |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | PINS | Write data |
| reg_rdata | output | PINS | Read data, registered |
| irq_out | output | 1 | Interrupt request |

## Verification
A sample strobed at clock edge k passes two synchronizer flops. An edge trigger therefore shows in status after edge k+2, and a level trigger after edge k+3, because the level is read from the stored sample. `irq_out` follows status or enable by one more edge, and read data arrives one edge after the read strobe. The bench lets every pin sample, register write and clear settle for at least four edges before it issues a read or looks at `irq_out`. It times its same-cycle clear so that the write lands in the edge where the trigger event is stored.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int ADDR_W = 3;
    typedef logic [ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t A_ENABLE = 3'd0;
    localparam reg_addr_t A_POLAR  = 3'd1;
    localparam reg_addr_t A_LEVEL  = 3'd2;
    localparam reg_addr_t A_DUAL   = 3'd3;
    localparam reg_addr_t A_STATUS = 3'd4;

    typedef enum logic [2:0] {
        TRIG_FALL,
        TRIG_RISE,
        TRIG_BOTH,
        TRIG_LVL_LO,
        TRIG_LVL_HI
    } trig_mode_e;

    typedef struct packed {
        logic hi_rise;
        logic level;
        logic dual;
    } trig_bits_t;

    function automatic trig_mode_e decode_mode(trig_bits_t b);
        if (b.level)
            return b.hi_rise ? TRIG_LVL_HI : TRIG_LVL_LO;
        else if (b.dual)
            return TRIG_BOTH;
        else
            return b.hi_rise ? TRIG_RISE : TRIG_FALL;
    endfunction

    function automatic logic trig_hit(trig_mode_e m, logic primed, logic vld,
                                      logic prev, logic cur);
        logic rise, fall;
        rise = primed & vld & cur & ~prev;
        fall = primed & vld & ~cur & prev;
        case (m)
            TRIG_FALL:   return fall;
            TRIG_RISE:   return rise;
            TRIG_BOTH:   return rise | fall;
            TRIG_LVL_LO: return primed & ~prev;
            TRIG_LVL_HI: return primed & prev;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pins_in,
    input  logic            pins_vld,
    output logic [PINS-1:0] pins_s,
    output logic            vld_s,
    output logic            primed
);
    logic [PINS-1:0] stage1;
    logic            vld1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            pins_s <= '0;
            vld1   <= 1'b0;
            vld_s  <= 1'b0;
            primed <= 1'b0;
        end else begin
            stage1 <= pins_in;
            pins_s <= stage1;
            vld1   <= pins_vld;
            vld_s  <= vld1;
            if (vld_s)
                primed <= 1'b1;
        end
    end
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  reg_addr_t       reg_addr,
    input  logic [PINS-1:0] reg_wdata,
    input  logic [PINS-1:0] stat,
    output logic [PINS-1:0] en_q,
    output logic [PINS-1:0] pol_q,
    output logic [PINS-1:0] lvl_q,
    output logic [PINS-1:0] dual_q,
    output logic [PINS-1:0] clr,
    output logic [PINS-1:0] reg_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pol_q  <= '0;
            lvl_q  <= '0;
            dual_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_ENABLE: en_q   <= reg_wdata;
                A_POLAR:  pol_q  <= reg_wdata;
                A_LEVEL:  lvl_q  <= reg_wdata;
                A_DUAL:   dual_q <= reg_wdata;
                default:  ;
            endcase
        end
    end

    assign clr = (reg_wr && reg_addr == A_STATUS) ? reg_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                A_ENABLE: reg_rdata <= en_q;
                A_POLAR:  reg_rdata <= pol_q;
                A_LEVEL:  reg_rdata <= lvl_q;
                A_DUAL:   reg_rdata <= dual_q;
                A_STATUS: reg_rdata <= stat;
                default:  reg_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/pin_irq_trigger.sv
module pin_irq_trigger
    import pin_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trig_mode_e mode,
    input  logic       primed,
    input  logic       vld,
    input  logic       cur,
    input  logic       clr,
    output logic       stat_q
);
    logic smp_q;
    logic hit;

    assign hit = trig_hit(mode, primed, vld, smp_q, cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q  <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            if (vld)
                smp_q <= cur;
            stat_q <= (stat_q & ~clr) | hit;
        end
    end
endmodule

// File: rtl/pin_irq_merge.sv
module pin_irq_merge #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] stat,
    input  logic [PINS-1:0] en,
    output logic            irq_q
);
    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |(stat & en);
    end
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
    import pin_irq_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pins_in,
    input  logic            pins_vld,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [2:0]      reg_addr,
    input  logic [PINS-1:0] reg_wdata,
    output logic [PINS-1:0] reg_rdata,
    output logic            irq_out
);
    logic [PINS-1:0] pins_s;
    logic            vld_s;
    logic            primed;
    logic [PINS-1:0] en_vec, pol_vec, lvl_vec, dual_vec, clr_vec, stat_vec;

    pin_irq_sync #(.PINS(PINS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pins_in (pins_in),
        .pins_vld(pins_vld),
        .pins_s  (pins_s),
        .vld_s   (vld_s),
        .primed  (primed)
    );

    pin_irq_regs #(.PINS(PINS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .stat     (stat_vec),
        .en_q     (en_vec),
        .pol_q    (pol_vec),
        .lvl_q    (lvl_vec),
        .dual_q   (dual_vec),
        .clr      (clr_vec),
        .reg_rdata(reg_rdata)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        trig_bits_t bits;
        trig_mode_e mode;
        assign bits = '{hi_rise: pol_vec[i], level: lvl_vec[i], dual: dual_vec[i]};
        assign mode = decode_mode(bits);

        pin_irq_trigger u_trig (
            .clk   (clk),
            .rst   (rst),
            .mode  (mode),
            .primed(primed),
            .vld   (vld_s),
            .cur   (pins_s[i]),
            .clr   (clr_vec[i]),
            .stat_q(stat_vec[i])
        );
    end

    pin_irq_merge #(.PINS(PINS)) u_merge (
        .clk  (clk),
        .rst  (rst),
        .stat (stat_vec),
        .en   (en_vec),
        .irq_q(irq_out)
    );
endmodule

// File: rtl/pin_irq_unit_chk.sv
module pin_irq_unit_chk #(
    parameter int PINS = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            irq_out,
    input logic [PINS-1:0] en,
    input logic [PINS-1:0] lvl,
    input logic [PINS-1:0] stat,
    input logic            vld,
    input logic            reg_wr,
    input logic [2:0]      reg_addr,
    input logic [PINS-1:0] reg_wdata
);
    // R1
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |=> !irq_out);

    // R9
    idle_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (stat == '0) |=> !irq_out);

    // R5
    zero_write_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd4 && reg_wdata == '0)
        |=> ((stat & $past(stat)) == $past(stat)));

    // R10
    no_sample_no_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!vld && lvl == '0) |=> ((stat & ~$past(stat)) == '0));

    // R7
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (en == '0 && lvl == '0 && stat == '0 && !irq_out));
endmodule

bind pin_irq_unit pin_irq_unit_chk #(.PINS(PINS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_out  (irq_out),
    .en       (en_vec),
    .lvl      (lvl_vec),
    .stat     (stat_vec),
    .vld      (vld_s),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata)
);

// File: tb/pin_irq_unit_bench.sv
module pin_irq_unit_bench;
    localparam int PINS = 32;
    localparam logic [2:0] A_EN = 3'd0, A_POL = 3'd1, A_LVL = 3'd2,
                           A_DUAL = 3'd3, A_STAT = 3'd4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PINS-1:0] pins_in = '0;
    logic            pins_vld = 1'b0;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [2:0]      reg_addr = '0;
    logic [PINS-1:0] reg_wdata = '0;
    logic [PINS-1:0] reg_rdata;
    logic            irq_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic rd_pend = 1'b0;

    logic [PINS-1:0] q_exp[$];
    string           q_tag[$];

    always #2 clk = ~clk;

    pin_irq_unit #(.PINS(PINS)) u_pin_irq_unit (
        .clk(clk), .rst(rst), .pins_in(pins_in), .pins_vld(pins_vld),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    always @(posedge clk) rd_pend <= reg_rd;

    // monitor: pops expected read data and compares
    always @(negedge clk) begin
        if (rd_pend && q_exp.size() > 0) begin
            logic [PINS-1:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            total++;
            if (reg_rdata !== e) begin
                bad++;
                $display("FAIL %s: rdata=%h expected=%h", t, reg_rdata, e);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [PINS-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, input logic [PINS-1:0] e, input string t);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        q_exp.push_back(e);
        q_tag.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic push(input logic [PINS-1:0] v);
        @(negedge clk);
        pins_in = v; pins_vld = 1'b1;
        @(negedge clk);
        pins_vld = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        total++;
        if (irq_out !== e) begin
            bad++;
            $display("FAIL %s: irq_out=%b expected=%b", t, irq_out, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R7 reset state
        rd(A_EN, '0, "R7 enable");
        rd(A_POL, '0, "R7 polarity");
        rd(A_LVL, '0, "R7 level");
        rd(A_DUAL, '0, "R7 dual");
        rd(A_STAT, '0, "R7 status");
        chk_irq(1'b0, "R7 irq");

        // R10 first sample only primes
        wr(A_POL, '1);
        push(32'h0000_00F0);
        rd(A_STAT, '0, "R10 priming sample");

        // R2 rising, R1 status without enable
        push(32'h0000_00F1);
        rd(A_STAT, 32'h1, "R2 rising edge pin0");
        chk_irq(1'b0, "R1 disabled pin");

        // R9 enable raises irq
        wr(A_EN, 32'h1);
        chk_irq(1'b1, "R9 enabled status");
        // R5 write zero keeps, write one clears
        wr(A_STAT, 32'h0);
        rd(A_STAT, 32'h1, "R5 write zero");
        wr(A_STAT, 32'h1);
        rd(A_STAT, 32'h0, "R5 write one");
        chk_irq(1'b0, "R9 cleared");

        // R10 changes without strobe ignored
        @(negedge clk);
        pins_in = '0;
        repeat (8) @(negedge clk);
        rd(A_STAT, '0, "R10 unstrobed change");

        // R2 falling
        wr(A_POL, '0);
        push(32'h0000_0000);
        rd(A_STAT, 32'h0000_00F1, "R2 falling edges");
        wr(A_STAT, '1);

        // R3 both edges
        wr(A_DUAL, 32'h0000_0300);
        push(32'h0000_0700);
        rd(A_STAT, 32'h0000_0300, "R3 rising in dual mode");
        wr(A_STAT, '1);
        push(32'h0000_0000);
        rd(A_STAT, 32'h0000_0700, "R3 falling in dual mode");
        wr(A_STAT, '1);
        wr(A_DUAL, '0);

        // R4 level modes: pin12 high, pin13 low
        wr(A_POL, 32'h0000_1000);
        wr(A_LVL, 32'h0000_3000);
        rd(A_STAT, 32'h0000_2000, "R4 level low active");
        wr(A_STAT, 32'h0000_2000);
        rd(A_STAT, 32'h0000_2000, "R4 clear while level held");
        push(32'h0000_3000);
        rd(A_STAT, 32'h0000_3000, "R4 level high active");
        wr(A_STAT, 32'h0000_3000);
        rd(A_STAT, 32'h0000_1000, "R4 low released");
        push(32'h0000_2000);
        wr(A_STAT, 32'h0000_3000);
        rd(A_STAT, 32'h0000_0000, "R4 both released");
        wr(A_LVL, '0);

        // R6 event and clear in same cycle (pin16 dual)
        wr(A_DUAL, 32'h0001_0000);
        push(32'h0001_2000);
        rd(A_STAT, 32'h0001_0000, "R8 status word pin16");
        chk_irq(1'b0, "R1 pin16 disabled");
        @(negedge clk);
        pins_in = 32'h0000_2000; pins_vld = 1'b1;
        @(negedge clk);
        pins_vld = 1'b0;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h0001_0000;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (3) @(negedge clk);
        rd(A_STAT, 32'h0001_0000, "R6 event beats clear");
        wr(A_STAT, 32'h0001_0000);
        rd(A_STAT, 32'h0, "R6 clear afterwards");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule